// File: doc/BRIEF.md
# Energy-Threshold Component Selector

This block picks how many leading components of a symmetric-matrix decomposition are worth keeping. After a start pulse it accepts a fixed number of unsigned fixed-point eigenvalue magnitudes, one per accepted beat of a valid/ready stream. The k-th accepted beat has original index k. While the values arrive, the block keeps them in descending order, each paired with its original index, and it accumulates their total.

Once the last value is in, the block walks the sorted list from the largest value down and keeps a running sum. It stops at the first count L for which the running sum reaches a programmable percentage of the total, or at a hard cap, whichever comes first. The comparison is done with widened integer products and no division. When the result is final, the block raises a one-cycle done pulse and holds the count. The sorted index list can then be read back by rank through a registered read port. A typical setting is 224 inputs, a cap of 24 and a threshold of 98 percent.

Top module: `energy_select`

## Requirements
- R1: After done, reading rank r on `rd_rank` returns on `rd_idx`, one clock later, the original index of the (r+1)-th largest value, so the list is in descending order of value.
- R2: Equal values are ordered with the lower original index at the lower rank.
- R3: `sel_count` is the smallest L for which 100 times the sum of the L largest values is greater than or equal to `thresh_pct` times the total of all values. Equality counts as reaching the threshold.
- R4: `sel_count` never exceeds MAX_SEL (default 24). When the threshold test and the cap fall on the same rank, the result is that rank.
- R5: When every input value is zero, `sel_count` is 1.
- R6: `in_ready` is high only between an accepted start (given while idle) and the acceptance of the last of NUM_VALS values. Valid beats outside that window are ignored and change neither the count nor the index list.
- R7: `done` is high for exactly one cycle per run, in the cycle in which `sel_count` takes its new value. `sel_count` holds that value until the next done.
- R8: The index list stays readable and unchanged from done until the next accepted start.
- R9: `thresh_pct` is sampled at the accepted start. Later changes do not affect the current run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run; honoured only while idle |
| thresh_pct | input | 7 | Energy threshold in percent, sampled at start |
| in_valid | input | 1 | Input value present |
| in_ready | output | 1 | Block accepts a value this cycle |
| in_data | input | VAL_W | Unsigned eigenvalue magnitude |
| done | output | 1 | One-cycle pulse when results are final |
| sel_count | output | CNT_W | Selected component count L |
| rd_rank | input | IDX_W | Rank to read from the sorted list |
| rd_idx | output | IDX_W | Original index at that rank, one cycle later |

## Verification
The threshold test and the hard cap can both end the walk on the same rank. The bench provokes this with 48 equal values of one and the rest zero, at 50 percent, so the test first passes exactly at the 24th rank, where the cap also ends the walk. It expects 24. Neighbouring settings are also run: one where the threshold passes a rank earlier (23), and one with equal nonzero values where only the cap ends the walk. Each result is judged against a count the bench computes from its own sorted copy of the inputs.

// File: rtl/energy_select_pkg.sv
package energy_select_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PICK = 2'd2
  } sel_state_t;

  localparam int PCT_W = 7;
endpackage

// File: rtl/energy_select_sorter.sv
// Insertion sorter: each new value enters below every stored value that is
// greater or equal (R1, R2: later index loses ties), lower entries shift down.
module energy_select_sorter #(
  parameter int NUM_VALS = 224,
  parameter int VAL_W    = 16,
  parameter int IDX_W    = $clog2(NUM_VALS)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              clr,
  input  logic                              ins_en,
  input  logic [VAL_W-1:0]                  ins_val,
  input  logic [IDX_W-1:0]                  ins_idx,
  output logic [NUM_VALS-1:0][VAL_W-1:0]    vals_o,
  output logic [NUM_VALS-1:0][IDX_W-1:0]    idxs_o
);
  logic [NUM_VALS-1:0] occ;
  logic [NUM_VALS-1:0] keep;
  logic [VAL_W-1:0]    val_q [NUM_VALS];
  logic [IDX_W-1:0]    idx_q [NUM_VALS];

  for (genvar k = 0; k < NUM_VALS; k++) begin : g_slot
    logic             above;
    logic [VAL_W-1:0] src_v;
    logic [IDX_W-1:0] src_i;
    logic             src_o;

    assign keep[k] = occ[k] && (val_q[k] >= ins_val);

    if (k == 0) begin : g_head
      assign above = 1'b1;
      assign src_v = ins_val;
      assign src_i = ins_idx;
      assign src_o = 1'b1;
    end else begin : g_body
      assign above = keep[k-1];
      assign src_v = val_q[k-1];
      assign src_i = idx_q[k-1];
      assign src_o = occ[k-1];
    end

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        occ[k] <= 1'b0;
      end else if (ins_en && !keep[k]) begin
        if (above) begin
          val_q[k] <= ins_val;
          idx_q[k] <= ins_idx;
          occ[k]   <= 1'b1;
        end else begin
          val_q[k] <= src_v;
          idx_q[k] <= src_i;
          occ[k]   <= src_o;
        end
      end
    end

    assign vals_o[k] = val_q[k];
    assign idxs_o[k] = idx_q[k];
  end
endmodule

// File: rtl/energy_select_walk.sv
// Accumulates the total during loading and walks the sorted list to find L.
module energy_select_walk #(
  parameter int NUM_VALS = 224,
  parameter int VAL_W    = 16,
  parameter int MAX_SEL  = 24,
  parameter int IDX_W    = $clog2(NUM_VALS),
  parameter int CNT_W    = $clog2(NUM_VALS + 1),
  parameter int PCT_W    = 7
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           clr,
  input  logic [PCT_W-1:0]               thr_i,
  input  logic                           acc_en,
  input  logic [VAL_W-1:0]               acc_val,
  input  logic                           walk_en,
  input  logic [NUM_VALS-1:0][VAL_W-1:0] vals_i,
  output logic                           hit_o,
  output logic [CNT_W-1:0]               cnt_o
);
  localparam int CAP    = (MAX_SEL < NUM_VALS) ? MAX_SEL : NUM_VALS;
  localparam int SUM_W  = VAL_W + CNT_W;
  localparam int PROD_W = SUM_W + PCT_W;

  logic [SUM_W-1:0]  total_q, run_q, sum_nxt;
  logic [IDX_W-1:0]  rank_q;
  logic [PCT_W-1:0]  thr_q;
  logic [PROD_W-1:0] lhs, rhs;

  assign sum_nxt = run_q + SUM_W'(vals_i[rank_q]);
  // R3: 100*running >= thr*total, no division
  assign lhs   = PROD_W'(sum_nxt) * PROD_W'(100);
  assign rhs   = PROD_W'(total_q) * PROD_W'(thr_q);
  // R4: cap ends the walk; R5 follows since 0 >= 0 at the first rank
  assign hit_o = walk_en && ((lhs >= rhs) || (rank_q == IDX_W'(CAP - 1)));
  assign cnt_o = CNT_W'(rank_q) + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      total_q <= '0;
      run_q   <= '0;
      rank_q  <= '0;
      thr_q   <= '0;
    end else if (clr) begin
      total_q <= '0;
      run_q   <= '0;
      rank_q  <= '0;
      thr_q   <= thr_i;   // R9
    end else begin
      if (acc_en)
        total_q <= total_q + SUM_W'(acc_val);
      if (walk_en && !hit_o) begin
        run_q  <= sum_nxt;
        rank_q <= rank_q + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/energy_select.sv
module energy_select
  import energy_select_pkg::*;
#(
  parameter int NUM_VALS = 224,
  parameter int VAL_W    = 16,
  parameter int MAX_SEL  = 24,
  parameter int IDX_W    = $clog2(NUM_VALS),
  parameter int CNT_W    = $clog2(NUM_VALS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [6:0]        thresh_pct,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VAL_W-1:0]  in_data,
  output logic              done,
  output logic [CNT_W-1:0]  sel_count,
  input  logic [IDX_W-1:0]  rd_rank,
  output logic [IDX_W-1:0]  rd_idx
);
  localparam logic [IDX_W:0] NUM_X = (IDX_W + 1)'(NUM_VALS);

  sel_state_t                     st_q;
  logic [IDX_W-1:0]               ld_cnt;
  logic                           clr, take, walk_en, hit, idle;
  logic [CNT_W-1:0]               cnt;
  logic [NUM_VALS-1:0][VAL_W-1:0] vals;
  logic [NUM_VALS-1:0][IDX_W-1:0] idxs;

  assign idle     = (st_q == ST_IDLE);
  assign clr      = idle && start;                  // R6, R8
  assign in_ready = (st_q == ST_LOAD);              // R6
  assign take     = in_ready && in_valid;
  assign walk_en  = (st_q == ST_PICK);

  energy_select_sorter #(
    .NUM_VALS(NUM_VALS), .VAL_W(VAL_W), .IDX_W(IDX_W)
  ) u_sorter (
    .clk(clk), .rst(rst), .clr(clr), .ins_en(take),
    .ins_val(in_data), .ins_idx(ld_cnt), .vals_o(vals), .idxs_o(idxs)
  );

  energy_select_walk #(
    .NUM_VALS(NUM_VALS), .VAL_W(VAL_W), .MAX_SEL(MAX_SEL),
    .IDX_W(IDX_W), .CNT_W(CNT_W), .PCT_W(PCT_W)
  ) u_walk (
    .clk(clk), .rst(rst), .clr(clr), .thr_i(thresh_pct),
    .acc_en(take), .acc_val(in_data), .walk_en(walk_en),
    .vals_i(vals), .hit_o(hit), .cnt_o(cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      ld_cnt    <= '0;
      done      <= 1'b0;
      sel_count <= '0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE: if (start) begin
          st_q   <= ST_LOAD;
          ld_cnt <= '0;
        end
        ST_LOAD: if (in_valid) begin
          ld_cnt <= ld_cnt + IDX_W'(1);
          if (ld_cnt == IDX_W'(NUM_VALS - 1)) st_q <= ST_PICK;
        end
        ST_PICK: if (hit) begin
          done      <= 1'b1;      // R7
          sel_count <= cnt;
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R1: registered read of the sorted index list
  always_ff @(posedge clk) begin
    if (rst)
      rd_idx <= '0;
    else if ({1'b0, rd_rank} < NUM_X)
      rd_idx <= idxs[rd_rank];
    else
      rd_idx <= '0;
  end
endmodule

// File: rtl/energy_select_chk.sv
module energy_select_chk #(
  parameter int CNT_W   = 8,
  parameter int MAX_SEL = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             idle,
  input logic             in_ready,
  input logic             done,
  input logic [CNT_W-1:0] sel_count
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                                   // R7
  AST_COUNT_BOUNDS: assert property (@(posedge clk) disable iff (rst)
    done |-> (sel_count >= CNT_W'(1) && sel_count <= CNT_W'(MAX_SEL))); // R4
  AST_IDLE_CLOSED: assert property (@(posedge clk) disable iff (rst)
    idle |-> !in_ready);                                               // R6
  AST_START_OPENS: assert property (@(posedge clk) disable iff (rst)
    (idle && start) |=> in_ready);                                     // R6
  AST_COUNT_HELD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(sel_count));                                     // R7
  AST_DONE_CLOSED: assert property (@(posedge clk) disable iff (rst)
    done |-> !in_ready);                                               // R6
endmodule

bind energy_select energy_select_chk #(.CNT_W(CNT_W), .MAX_SEL(MAX_SEL)) i_chk (
  .clk(clk), .rst(rst), .start(start), .idle(idle), .in_ready(in_ready),
  .done(done), .sel_count(sel_count)
);

// File: tb/test_energy_select.sv
`timescale 1ns/1ps
module test_energy_select;
  localparam int N  = 224;
  localparam int VW = 16;
  localparam int MS = 24;
  localparam int IW = $clog2(N);
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [6:0]    thresh_pct = 7'd98;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [VW-1:0] in_data = '0;
  logic          done;
  logic [CW-1:0] sel_count;
  logic [IW-1:0] rd_rank = '0;
  logic [IW-1:0] rd_idx;

  int total_checks = 0;
  int bad_checks   = 0;
  int cycles       = 0;

  logic [VW-1:0] vin [N];
  int            exp_ord [N];
  int            exp_l;

  always #10 clk = ~clk;

  energy_select #(.NUM_VALS(N), .VAL_W(VW), .MAX_SEL(MS)) i_energy_select (
    .clk(clk), .rst(rst), .start(start), .thresh_pct(thresh_pct),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .done(done), .sel_count(sel_count), .rd_rank(rd_rank), .rd_idx(rd_idx)
  );

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad_checks = bad_checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    total_checks++;
    if (act != exp) begin
      bad_checks++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference: descending by value, lower index first on ties; L by threshold/cap
  task automatic model(input int thr);
    bit     used [N];
    longint tot = 0, run = 0;
    for (int i = 0; i < N; i++) begin used[i] = 0; tot += vin[i]; end
    for (int r = 0; r < N; r++) begin
      int best = -1;
      for (int j = 0; j < N; j++)
        if (!used[j] && (best < 0 || vin[j] > vin[best])) best = j;
      used[best] = 1;
      exp_ord[r] = best;
    end
    exp_l = 0;
    for (int k = 1; k <= MS; k++) begin
      run += vin[exp_ord[k-1]];
      exp_l = k;
      if (100 * run >= longint'(thr) * tot) break;
    end
  endtask

  task automatic check_list(input string req);
    int miss = 0, first_act = 0, first_exp = 0;
    for (int r = 0; r < N; r++) begin
      @(negedge clk); rd_rank = IW'(r);
      @(negedge clk);
      if (int'(rd_idx) != exp_ord[r]) begin
        if (miss == 0) begin first_act = int'(rd_idx); first_exp = exp_ord[r]; end
        miss++;
      end
    end
    check({req, " list"}, first_act, first_exp);
    check({req, " list mismatches"}, miss, 0);
  endtask

  // Start, stream values (optional bubbles), wait for done; thr2 applied after start
  task automatic run_case(input string req, input int thr, input int thr2, input bit bubbles);
    int i = 0, n = 0, wait_cyc = 0;
    bit got = 0;
    model(thr);
    @(negedge clk); thresh_pct = 7'(thr); start = 1'b1;
    @(negedge clk); start = 1'b0; thresh_pct = 7'(thr2);
    while (i < N) begin
      bit rdy = in_ready;
      if (bubbles && (n % 3 == 2)) begin
        in_valid = 1'b0;
      end else begin
        in_valid = 1'b1; in_data = vin[i];
        if (rdy) i++;
      end
      n++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    while (!got && wait_cyc < 400) begin
      if (done) got = 1; else begin @(negedge clk); wait_cyc++; end
    end
    check({req, " done seen"}, got, 1);
    check({req, " count"}, sel_count, exp_l);
    @(negedge clk);
    check({req, " done one cycle R7"}, done, 0);
    check({req, " ready low after run R6"}, in_ready, 0);
    check_list(req);
  endtask

  task automatic t_reset();
    check("R6 reset ready", in_ready, 0);
    check("R7 reset done", done, 0);
    check("R7 reset count", sel_count, 0);
  endtask

  task automatic t_idle_ignore();
    for (int c = 0; c < 5; c++) begin
      @(negedge clk); in_valid = 1'b1; in_data = 16'hFFFF;
      check("R6 idle ready low", in_ready, 0);
    end
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic t_spike();   // index 5 holds all energy; zeros tie by index
    for (int i = 0; i < N; i++) vin[i] = '0;
    vin[5] = 16'd1000;
    run_case("R1 R2 R3 spike", 98, 98, 0);
  endtask

  task automatic t_zero();
    for (int i = 0; i < N; i++) vin[i] = '0;
    run_case("R5 R2 all zero", 98, 98, 0);
    check("R5 count one", sel_count, 1);
  endtask

  task automatic t_uniform(); // threshold needs 220, cap wins
    for (int i = 0; i < N; i++) vin[i] = 16'd10;
    run_case("R4 uniform cap", 98, 98, 0);
    check("R4 count cap", sel_count, 24);
  endtask

  task automatic t_exact();
    for (int i = 0; i < N; i++) vin[i] = '0;
    vin[7] = 16'd300; vin[3] = 16'd100;
    run_case("R9 R3 thr 76 then 75", 76, 75, 0);
    check("R9 sampled threshold", sel_count, 2);
    run_case("R3 equality counts", 75, 75, 0);
    check("R3 equality count", sel_count, 1);
  endtask

  task automatic t_coincide();
    for (int i = 0; i < N; i++) vin[i] = (i < 48) ? 16'd1 : 16'd0;
    run_case("R3 R4 coincide", 50, 50, 0);
    check("R4 coincide count", sel_count, 24);
    run_case("R3 below cap", 47, 47, 1);
    check("R3 below cap count", sel_count, 23);
  endtask

  task automatic t_mixed();
    for (int i = 0; i < N; i++) vin[i] = VW'(((i * 73 + 11) % 97) * (i % 5 + 1));
    run_case("R1 R2 R3 mixed", 90, 90, 1);
  endtask

  task automatic t_hold();    // R8, R6: idle beats leave results untouched
    int c0 = int'(sel_count);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk); in_valid = 1'b1; in_data = 16'hFFFF;
    end
    @(negedge clk); in_valid = 1'b0;
    check("R7 count held", sel_count, c0);
    check_list("R8 R6 list held");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_idle_ignore();
    t_spike();
    t_zero();
    t_uniform();
    t_exact();
    t_coincide();
    t_mixed();
    t_hold();
    summary();
    $finish;
  end
endmodule